// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Word Queue

This block takes 32-bit words from a host, supplied as a lower and an upper 16-bit half, and holds them in a 32-entry first-in, first-out queue. It sends each word on two return-to-zero lines. The "one" line pulses for a logic 1 and the "zero" line pulses for a logic 0. Each bit cell ends with a null period in which both lines are low, and every word is followed by a fixed gap of four null bit cells. The first bit sent is bit 0 of the host word.

Bit 31 of each word is either sent as loaded or replaced by a generated parity bit, and the parity can be odd or even. The host starts a transmission with an enable input. Once a transmission has started, the block keeps sending until the queue is empty. Three status outputs serve the host: ready/empty, half full and full. A synchronous reset stops the line at once and drops all queued words.

Top module: `a429_tx_fifo`

## Requirements
- R1: Each bit cell lasts 10 clocks when `speed_lo`=0 and 80 clocks when `speed_lo`=1. One line is active for the first 5 (or 40) clocks of the cell, and both lines are low for the rest. The speed is sampled when a word leaves the queue.
- R2: For a 1 bit only `line_one` is active, and for a 0 bit only `line_zero` is active. The two lines are never high together. Bit 0 of the word is sent first and bit 31 last.
- R3: After the 32nd bit cell of every word, both lines stay low for 4 bit cells (40 or 320 clocks) before the next word may begin.
- R4: A one-cycle `ld_lo` strobe captures `din` as bits 15:0. A later `ld_hi` strobe stores {`din`, captured half} as one word. An `ld_hi` strobe with no captured lower half pending stores nothing.
- R5: The queue holds 32 words and sends them in load order. `fifo_full` is 1 exactly when 32 words are held. A store attempted while the queue is full is dropped and never transmitted.
- R6: `half_full` is 1 exactly when 16 or more words are held.
- R7: `tx_ready` is 1 after reset. It goes to 0 in the clock after a word is stored. It returns to 1 when the 32nd bit cell of the last queued word ends.
- R8: With `par_en`=1, bit 31 is replaced by parity over bits 30:0. With `par_even`=0 the 32 bits sent hold an odd number of ones, and with `par_even`=1 they hold an even number. The parity controls are sampled when the word leaves the queue.
- R9: With `par_en`=0, all 32 stored bits are sent unchanged.
- R10: While the line is idle and the queue is not empty, a clock edge that sees `tx_en`=1 starts a word, and the first bit cell is active from that edge on. While `tx_en` stays 0 in idle, nothing is sent.
- R11: Once started, words continue back to back, each separated by the R3 gap, until the queue is empty, whatever the value of `tx_en`.
- R12: A clock edge with `rst`=1 returns both lines to low, empties the queue, clears `half_full` and `fifo_full`, sets `tx_ready`, and discards any word in progress.

Port `rst` is a synchronous reset, active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| speed_lo | input | 1 | 1 selects 80-clock bit cells, 0 selects 10-clock bit cells |
| par_en | input | 1 | 1 replaces bit 31 with generated parity |
| par_even | input | 1 | Parity sense: 0 gives odd parity, 1 gives even parity |
| tx_en | input | 1 | Starts transmission from idle |
| ld_lo | input | 1 | Strobe that captures the lower half |
| ld_hi | input | 1 | Strobe that supplies the upper half and stores the word |
| din | input | 16 | Host data half |
| line_one | output | 1 | Return-to-zero "one" line |
| line_zero | output | 1 | Return-to-zero "zero" line |
| tx_ready | output | 1 | Queue empty and no bit cell in progress |
| half_full | output | 1 | 16 or more words held |
| fifo_full | output | 1 | 32 words held |

## Verification
The assertions assume that the load strobes, `din`, `speed_lo` and the parity controls change only between clock edges. They also assume that `rst` is high at the first edge, so the reset check has defined state to compare against. The stimulus drives every input on the falling clock edge and holds the rate and parity controls steady while a word is on the line. Each strobe is a single cycle, with `ld_lo` always ahead of `ld_hi` except in the one case that deliberately sends an unpaired upper strobe. `tx_en` is dropped one cycle after each start, so the checks also show that transmission continues without it.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_BIT  = 2'd1,
    SER_GAP  = 2'd2
  } ser_state_e;

  // Parity bit over the 31 data bits: even_sel=0 makes the whole word odd.
  function automatic logic par_bit(input logic [WORD_W-2:0] d, input logic even_sel);
    return even_sel ? (^d) : ~(^d);
  endfunction

  // Word as it goes on the line.
  function automatic logic [WORD_W-1:0] line_word(input logic [WORD_W-1:0] w,
                                                  input logic par_on,
                                                  input logic even_sel);
    return par_on ? {par_bit(w[WORD_W-2:0], even_sel), w[WORD_W-2:0]} : w;
  endfunction

endpackage

// File: rtl/a429_tx_load.sv
module a429_tx_load #(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [HW-1:0]   din,
  output logic            store_req,
  output logic [2*HW-1:0] store_word
);

  logic [HW-1:0] lo_hold;
  logic          lo_pend;

  assign store_req  = ld_hi && lo_pend;
  assign store_word = {din, lo_hold};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_hold <= '0;
      lo_pend <= 1'b0;
    end else begin
      if (ld_hi) lo_pend <= 1'b0;
      if (ld_lo) begin
        lo_hold <= din;
        lo_pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/a429_tx_store.sv
module a429_tx_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             half,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign half    = (count >= CW'(DEPTH / 2));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
  import a429_tx_pkg::*;
#(
  parameter int HALF_HI  = 5,
  parameter int HALF_LO  = 40,
  parameter int GAP_BITS = 4,
  parameter int WBITS    = 32,
  localparam int BIT_HI  = 2 * HALF_HI,
  localparam int BIT_LO  = 2 * HALF_LO,
  localparam int GAP_HI  = GAP_BITS * BIT_HI,
  localparam int GAP_LO  = GAP_BITS * BIT_LO,
  localparam int CNTW    = $clog2(GAP_LO + 1),
  localparam int IDXW    = $clog2(WBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             speed_lo,
  input  logic             fifo_empty,
  input  logic [WBITS-1:0] fifo_word,
  output logic             pop,
  output logic             line_one,
  output logic             line_zero,
  output logic             in_bit,
  output logic             in_gap,
  output logic             gap_done
);

  ser_state_e       state;
  logic [CNTW-1:0]  cnt;
  logic [IDXW-1:0]  idx;
  logic [WBITS-1:0] sh;
  logic             speed_q;
  logic [CNTW-1:0]  bit_len, half_len, gap_len;
  logic             cell_end, active;

  assign bit_len  = speed_q ? CNTW'(BIT_LO)  : CNTW'(BIT_HI);
  assign half_len = speed_q ? CNTW'(HALF_LO) : CNTW'(HALF_HI);
  assign gap_len  = speed_q ? CNTW'(GAP_LO)  : CNTW'(GAP_HI);

  assign in_bit   = (state == SER_BIT);
  assign in_gap   = (state == SER_GAP);
  assign gap_done = in_gap && (cnt == gap_len - 1'b1);
  assign cell_end = in_bit && (cnt == bit_len - 1'b1);
  assign pop      = !fifo_empty && (((state == SER_IDLE) && tx_en) || gap_done);

  assign active    = in_bit && (cnt < half_len);
  assign line_one  = active && sh[0];
  assign line_zero = active && !sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SER_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      speed_q <= 1'b0;
    end else begin
      case (state)
        SER_IDLE: begin
          if (pop) begin
            state   <= SER_BIT;
            cnt     <= '0;
            idx     <= '0;
            sh      <= fifo_word;
            speed_q <= speed_lo;
          end
        end
        SER_BIT: begin
          if (cell_end) begin
            cnt <= '0;
            if (idx == IDXW'(WBITS - 1)) begin
              state <= SER_GAP;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
              sh  <= sh >> 1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SER_GAP: begin
          if (gap_done) begin
            cnt <= '0;
            if (pop) begin
              state   <= SER_BIT;
              idx     <= '0;
              sh      <= fifo_word;
              speed_q <= speed_lo;
            end else begin
              state <= SER_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SER_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo
  import a429_tx_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int HALF_HI  = 5,
  parameter int HALF_LO  = 40,
  parameter int GAP_BITS = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              speed_lo,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              tx_en,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] din,
  output logic              line_one,
  output logic              line_zero,
  output logic              tx_ready,
  output logic              half_full,
  output logic              fifo_full
);

  // Named internal events, visible to the bound checker.
  logic              store_req;
  logic [WORD_W-1:0] store_word;
  logic              word_start;
  logic [WORD_W-1:0] head_word;
  logic [WORD_W-1:0] framed_word;
  logic [CW-1:0]     fifo_count;
  logic              fifo_empty;
  logic              in_bit, in_gap, gap_done;

  a429_tx_load #(.HW(HALF_W)) u_load (
    .clk        (clk),
    .rst        (rst),
    .ld_lo      (ld_lo),
    .ld_hi      (ld_hi),
    .din        (din),
    .store_req  (store_req),
    .store_word (store_word)
  );

  a429_tx_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .push  (store_req),
    .wdata (store_word),
    .pop   (word_start),
    .rdata (head_word),
    .count (fifo_count),
    .empty (fifo_empty),
    .half  (half_full),
    .full  (fifo_full)
  );

  assign framed_word = line_word(head_word, par_en, par_even);

  a429_tx_ser #(
    .HALF_HI  (HALF_HI),
    .HALF_LO  (HALF_LO),
    .GAP_BITS (GAP_BITS),
    .WBITS    (WORD_W)
  ) u_ser (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .speed_lo   (speed_lo),
    .fifo_empty (fifo_empty),
    .fifo_word  (framed_word),
    .pop        (word_start),
    .line_one   (line_one),
    .line_zero  (line_zero),
    .in_bit     (in_bit),
    .in_gap     (in_gap),
    .gap_done   (gap_done)
  );

  assign tx_ready = fifo_empty && !in_bit;

endmodule

// File: rtl/a429_tx_fifo_chk.sv
module a429_tx_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          line_one,
  input logic          line_zero,
  input logic          tx_ready,
  input logic          half_full,
  input logic          fifo_full,
  input logic          store_req,
  input logic          word_start,
  input logic [CW-1:0] fifo_count,
  input logic          fifo_empty,
  input logic          in_gap,
  input logic          gap_done
);

  // R2
  lines_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_one && line_zero));

  // R3
  gap_null_chk: assert property (@(posedge clk) disable iff (rst)
    in_gap |-> (!line_one && !line_zero));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && store_req && !word_start) |=> (fifo_full && $stable(fifo_count)));

  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH));

  // R6
  half_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(half_full) |-> $past(store_req));

  // R7
  ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_ready) |-> $past(store_req));

  // R10
  start_latency_chk: assert property (@(posedge clk) disable iff (rst)
    word_start |=> (line_one || line_zero));

  // R11
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (gap_done && !fifo_empty) |-> word_start);

  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!line_one && !line_zero && tx_ready && !half_full && !fifo_full));

endmodule

bind a429_tx_fifo a429_tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_one   (line_one),
  .line_zero  (line_zero),
  .tx_ready   (tx_ready),
  .half_full  (half_full),
  .fifo_full  (fifo_full),
  .store_req  (store_req),
  .word_start (word_start),
  .fifo_count (fifo_count),
  .fifo_empty (fifo_empty),
  .in_gap     (in_gap),
  .gap_done   (gap_done)
);

// File: tb/a429_tx_fifo_test.sv
module a429_tx_fifo_test;

  localparam int BLEN_HI = 10;
  localparam int BLEN_LO = 80;
  localparam int NVEC    = 8;
  // {par_en, par_even, word}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'b10, 32'h0000_0000},
    {2'b11, 32'h0000_0000},
    {2'b10, 32'hFFFF_FFFF},
    {2'b11, 32'h7FFF_FFFF},
    {2'b00, 32'hA5A5_5A5A},
    {2'b00, 32'h8000_0001},
    {2'b10, 32'h1234_5678},
    {2'b11, 32'hDEAD_BEEF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        speed_lo = 1'b0, par_en = 1'b0, par_even = 1'b0, tx_en = 1'b0;
  logic        ld_lo = 1'b0, ld_hi = 1'b0;
  logic [15:0] din = '0;
  logic        line_one, line_zero, tx_ready, half_full, fifo_full;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  a429_tx_fifo uut (
    .clk(clk), .rst(rst), .speed_lo(speed_lo), .par_en(par_en), .par_even(par_even),
    .tx_en(tx_en), .ld_lo(ld_lo), .ld_hi(ld_hi), .din(din),
    .line_one(line_one), .line_zero(line_zero), .tx_ready(tx_ready),
    .half_full(half_full), .fifo_full(fifo_full)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input bit pe, input bit ev);
    int ones = 0;
    for (int i = 0; i < 31; i++) ones += int'(w[i]);
    if (!pe) return w;
    return {(ev ? (ones % 2 == 1) : (ones % 2 == 0)), w[30:0]};
  endfunction

  // Called at a falling edge; ends at a falling edge after the word is stored.
  task automatic load_word(input logic [31:0] w);
    din = w[15:0]; ld_lo = 1'b1;
    @(negedge clk);
    ld_lo = 1'b0; din = w[31:16]; ld_hi = 1'b1;
    @(negedge clk);
    ld_hi = 1'b0;
  endtask

  task automatic start_tx();
    tx_en = 1'b1;
    @(negedge clk);
    tx_en = 1'b0;
  endtask

  task automatic take_word(input int blen, output logic [31:0] got, output bit shape_ok);
    shape_ok = 1'b1;
    got = '0;
    for (int c = 0; c < 32 * blen; c++) begin
      int k;
      int j;
      k = c / blen;
      j = c % blen;
      if (j < blen / 2) begin
        if (line_one == line_zero) shape_ok = 1'b0;
        if (j == 0) got[k] = line_one;
        else if (got[k] != line_one) shape_ok = 1'b0;
      end else if (line_one || line_zero) begin
        shape_ok = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic watch_null(input int n, output bit ok);
    ok = 1'b1;
    for (int c = 0; c < n; c++) begin
      if (line_one || line_zero) ok = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] got;
    logic [31:0] exp;
    bit          ok;
    bit          gap_ok;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 / R7: reset state
    check(!line_one && !line_zero, "R12 lines low", {30'd0, line_one, line_zero}, 32'd0);
    check(tx_ready, "R7 ready after reset", {31'd0, tx_ready}, 32'd1);
    check(!half_full && !fifo_full, "R12 flags clear", {30'd0, half_full, fifo_full}, 32'd0);

    // R4: upper strobe without lower half stores nothing
    din = 16'hBEEF; ld_hi = 1'b1;
    @(negedge clk);
    ld_hi = 1'b0;
    @(negedge clk);
    check(tx_ready, "R4 unpaired upper strobe ignored", {31'd0, tx_ready}, 32'd1);

    // Vector table: R2, R4, R8, R9, R1, R3, R7
    for (int v = 0; v < NVEC; v++) begin
      par_en   = VEC[v][33];
      par_even = VEC[v][32];
      load_word(VEC[v][31:0]);
      check(!tx_ready, "R7 ready drops on store", {31'd0, tx_ready}, 32'd0);
      start_tx();
      take_word(BLEN_HI, got, ok);
      exp = expect_word(VEC[v][31:0], VEC[v][33], VEC[v][32]);
      check(got == exp, VEC[v][33] ? "R8 parity word / R2 order" : "R9 raw word / R2 order", got, exp);
      check(ok, "R1 high-speed cell shape", {31'd0, ok}, 32'd1);
      check(tx_ready, "R7 ready after last cell", {31'd0, tx_ready}, 32'd1);
      watch_null(4 * BLEN_HI, gap_ok);
      check(gap_ok, "R3 word gap null", {31'd0, gap_ok}, 32'd1);
    end

    // R5 / R6: fill the queue, then one extra store
    par_en = 1'b0;
    for (int i = 0; i < 32; i++) begin
      load_word(32'h1000_0000 + i * 32'h0101_0101);
      if (i == 14) check(!half_full, "R6 half clear at 15", {31'd0, half_full}, 32'd0);
      if (i == 15) check(half_full, "R6 half set at 16", {31'd0, half_full}, 32'd1);
      if (i == 30) check(!fifo_full, "R5 full clear at 31", {31'd0, fifo_full}, 32'd0);
    end
    check(fifo_full, "R5 full at 32", {31'd0, fifo_full}, 32'd1);
    load_word(32'hCAFE_F00D);
    check(fifo_full, "R5 still full after dropped store", {31'd0, fifo_full}, 32'd1);
    // R11: enable is only one cycle; all 32 must go out in order
    start_tx();
    for (int i = 0; i < 32; i++) begin
      take_word(BLEN_HI, got, ok);
      exp = 32'h1000_0000 + i * 32'h0101_0101;
      check(got == exp && ok, "R5 R11 queued word in order", got, exp);
      watch_null(4 * BLEN_HI, gap_ok);
      check(gap_ok, "R3 gap between queued words", {31'd0, gap_ok}, 32'd1);
    end
    watch_null(400, ok);
    check(ok && tx_ready, "R5 dropped word never sent", {31'd0, ok}, 32'd1);

    // R10: nothing sent while enable is low; then low-speed word (R1)
    speed_lo = 1'b1;
    par_en = 1'b1; par_even = 1'b0;
    load_word(32'h0F0F_3C3C);
    watch_null(50, ok);
    check(ok && !tx_ready, "R10 idle while enable low", {31'd0, ok}, 32'd1);
    start_tx();
    take_word(BLEN_LO, got, ok);
    exp = expect_word(32'h0F0F_3C3C, 1'b1, 1'b0);
    check(got == exp, "R1 R8 low-speed word", got, exp);
    check(ok, "R1 low-speed cell shape", {31'd0, ok}, 32'd1);
    watch_null(4 * BLEN_LO, gap_ok);
    check(gap_ok, "R3 low-speed gap", {31'd0, gap_ok}, 32'd1);

    // R12: reset in mid-word
    speed_lo = 1'b0;
    load_word(32'hFFFF_0000);
    load_word(32'h0000_FFFF);
    start_tx();
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!line_one && !line_zero, "R12 lines low after reset", {30'd0, line_one, line_zero}, 32'd0);
    check(tx_ready && !half_full, "R12 queue emptied", {30'd0, tx_ready, half_full}, 32'd2);
    tx_en = 1'b1;
    watch_null(400, ok);
    tx_en = 1'b0;
    check(ok, "R12 no residual words sent", {31'd0, ok}, 32'd1);

    report();
  end

endmodule